// File: doc/BRIEF.md
# Multi-Input Edge Wake-Up Unit

The unit watches sixteen asynchronous input lines and turns selected edges on them into interrupt requests and a wake-up request. Every line is first brought into the clock domain by a two-flop synchroniser. An edge detector then looks for either a rising or a falling transition on each line, as that line's polarity bit selects. A detected edge on an enabled line sets a sticky pending flag. The flag stays set until software writes a one to its bit.

Each line carries a 2-bit selector that assigns it to one of four level-sensitive request outputs. An output is high while any enabled line routed to it has its pending flag set. A separate wake-up output is high while any enabled line is pending, whatever its route, so a power manager can use it to leave a halt, idle or power-save state. Software sets up enables, polarities and routes, and clears pending flags, through a simple write port. A combinational read port returns the contents of every register.

Top module: `edge_wake_unit`

## Requirements
- R1: After reset the enable, polarity, pending and route registers all read zero, and `irq_o` and `wake_o` are low.
- R2: Polarity bit 1 makes a line respond to a rising edge and bit 0 to a falling edge. The opposite edge is ignored. Counting from the clock edge that first samples the new input level, the pending flag can be read on the third rising clock edge.
- R3: An edge on a line whose enable bit is 0 does not set that line's pending flag.
- R4: Pending flags are sticky. Writing to address 2 clears each flag whose data bit is 1 and leaves the flags whose data bits are 0 unchanged.
- R5: The route of line i is held at address 3 + i/8, bits [2*(i%8)+1 : 2*(i%8)]. `irq_o[k]` is the OR of the lines that are both enabled and pending and whose route equals k.
- R6: `wake_o` is the OR of the lines that are both enabled and pending, whatever their routes.
- R7: Toggling a line's polarity bit while its input is steady does not set its pending flag.
- R8: Clearing the enable bit of a pending line removes that line from `irq_o` and `wake_o`, but its pending flag still reads back as set.
- R9: Address 0 reads the enable mask, address 1 the polarity mask, address 2 the pending flags, and addresses 3 and 4 the route words. Addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the unit. |
| chan_i | input | 16 | Asynchronous input lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Register read data, combinational from rd_addr_i |
| irq_o | output | 4 | Level interrupt requests, one per route value |
| wake_o | output | 1 | Wake-up request |

## Verification
The bench flips polarity bits while the inputs are held high, to catch a detector that compares the input against the polarity bit instead of against the input's previous level; such a detector would raise pending flags with no real edge. It disables a line that is already pending, to show that a design which clears the flag, or keeps routing it, is wrong. Random route assignments expose a selector decoded with the wrong bit offset, which would drive a request line the line was never routed to. Writes of zero to the pending register expose a clear that acts on the whole register instead of by bit mask.

// File: rtl/ewu_pkg.sv
package ewu_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_ENABLE   = 3'd0;
  localparam logic [ADDR_W-1:0] A_POLARITY = 3'd1;
  localparam logic [ADDR_W-1:0] A_PENDING  = 3'd2;
  localparam logic [ADDR_W-1:0] A_ROUTE0   = 3'd3;
endpackage

// File: rtl/ewu_rst_sync.sv
module ewu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ewu_sync.sv
module ewu_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ewu_edge.sv
module ewu_edge #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] rise_sel_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  // Detection compares real transitions of the line only, so a polarity
  // change with a steady input cannot produce an event.
  always_comb begin
    evt_o = (level_i & ~prev_q & rise_sel_i) | (~level_i & prev_q & ~rise_sel_i);
  end
endmodule

// File: rtl/ewu_route.sv
module ewu_route #(
  parameter int unsigned NCH  = 16,
  parameter int unsigned NOUT = 4,
  localparam int unsigned SEL_W = $clog2(NOUT)
) (
  input  logic [NCH-1:0]            active_i,
  input  logic [NCH-1:0][SEL_W-1:0] sel_i,
  output logic [NOUT-1:0]           req_o
);
  for (genvar k = 0; k < NOUT; k++) begin : g_out
    logic [NCH-1:0] hit;
    always_comb begin
      for (int i = 0; i < NCH; i++) begin
        hit[i] = active_i[i] && (sel_i[i] == SEL_W'(k));
      end
    end
    assign req_o[k] = |hit;
  end
endmodule

// File: rtl/edge_wake_unit.sv
module edge_wake_unit
  import ewu_pkg::*;
#(
  parameter int unsigned NCH         = 16,
  parameter int unsigned NOUT        = 4,
  parameter int unsigned DW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      chan_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DW-1:0]       wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DW-1:0]       rd_data_o,
  output logic [NOUT-1:0]     irq_o,
  output logic                wake_o
);
  localparam int unsigned SEL_W      = $clog2(NOUT);
  localparam int unsigned PER_REG    = DW / SEL_W;
  localparam int unsigned ROUTE_REGS = (NCH + PER_REG - 1) / PER_REG;

  logic rst_n_s;
  logic [NCH-1:0] level, evt;
  logic [NCH-1:0] en_q, en_d, pol_q, pol_d, pend_q, pend_d, clr;
  logic [NCH-1:0][SEL_W-1:0] route_q, route_d;
  logic en_we, pol_we, route_we, pend_we;

  ewu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  ewu_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i(chan_i), .q_o(level)
  );

  ewu_edge #(.W(NCH)) u_edge (
    .clk(clk), .rst_n(rst_n_s), .level_i(level), .rise_sel_i(pol_q), .evt_o(evt)
  );

  // Next-state logic
  always_comb begin
    en_we    = wr_en_i && (wr_addr_i == A_ENABLE);
    pol_we   = wr_en_i && (wr_addr_i == A_POLARITY);
    en_d     = wr_data_i[NCH-1:0];
    pol_d    = wr_data_i[NCH-1:0];
    clr      = (wr_en_i && (wr_addr_i == A_PENDING)) ? wr_data_i[NCH-1:0] : '0;
    pend_d   = (pend_q & ~clr) | (evt & en_q);
    pend_we  = (|clr) || (|(evt & en_q));
    route_we = 1'b0;
    route_d  = route_q;
    for (int r = 0; r < ROUTE_REGS; r++) begin
      if (wr_en_i && (wr_addr_i == A_ROUTE0 + ADDR_W'(r))) begin
        route_we = 1'b1;
        for (int j = 0; j < PER_REG; j++) begin
          if (r * PER_REG + j < NCH) begin
            route_d[r * PER_REG + j] = wr_data_i[j * SEL_W +: SEL_W];
          end
        end
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      en_q    <= '0;
      pol_q   <= '0;
      pend_q  <= '0;
      route_q <= '0;
    end else begin
      if (en_we)    en_q    <= en_d;
      if (pol_we)   pol_q   <= pol_d;
      if (pend_we)  pend_q  <= pend_d;
      if (route_we) route_q <= route_d;
    end
  end

  // Read mux
  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_ENABLE:   rd_data_o = DW'(en_q);
      A_POLARITY: rd_data_o = DW'(pol_q);
      A_PENDING:  rd_data_o = DW'(pend_q);
      default: begin
        for (int r = 0; r < ROUTE_REGS; r++) begin
          if (rd_addr_i == A_ROUTE0 + ADDR_W'(r)) begin
            for (int j = 0; j < PER_REG; j++) begin
              if (r * PER_REG + j < NCH) begin
                rd_data_o[j * SEL_W +: SEL_W] = route_q[r * PER_REG + j];
              end
            end
          end
        end
      end
    endcase
  end

  ewu_route #(.NCH(NCH), .NOUT(NOUT)) u_route (
    .active_i(pend_q & en_q), .sel_i(route_q), .req_o(irq_o)
  );

  assign wake_o = |(pend_q & en_q);
endmodule

// File: rtl/ewu_checker.sv
module ewu_checker
  import ewu_pkg::*;
#(
  parameter int unsigned NCH  = 16,
  parameter int unsigned NOUT = 4,
  parameter int unsigned DW   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic [NOUT-1:0]   irq,
  input logic              wake,
  input logic [NCH-1:0]    pend,
  input logic [NCH-1:0]    en,
  input logic [NCH-1:0]    evt
);
  AST_WAKE_IS_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
    wake == (|irq)); // R6

  AST_IRQ_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> (|(pend & en))); // R8

  AST_PEND_ONLY_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(evt & en)) == '0)); // R3

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_PENDING) |=>
      ((pend & $past(wr_data[NCH-1:0] & ~(evt & en))) == '0)); // R4

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_PENDING) |=> (($past(pend) & ~pend) == '0)); // R4
endmodule

bind edge_wake_unit ewu_checker #(.NCH(NCH), .NOUT(NOUT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
  .wr_data(wr_data_i), .irq(irq_o), .wake(wake_o), .pend(pend_q),
  .en(en_q), .evt(evt)
);

// File: tb/sim_edge_wake_unit.sv
module sim_edge_wake_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] chan = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [3:0]  irq;
  logic        wake;

  always #2 clk = ~clk;

  edge_wake_unit u0 (
    .clk(clk), .rst_n(rst_n), .chan_i(chan), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .irq_o(irq), .wake_o(wake)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] m_en = '0, m_pol = '0, m_pend = '0;
  logic [1:0]  m_route [16];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    rd_addr = a[2:0];
    #1;
    d = rd_data;
  endtask

  function automatic logic [15:0] route_word(input int r);
    logic [15:0] w = '0;
    for (int j = 0; j < 8; j++) w[2*j +: 2] = m_route[r*8 + j];
    return w;
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] v = '0;
    for (int i = 0; i < 16; i++)
      if (m_pend[i] && m_en[i]) v[m_route[i]] = 1'b1;
    return v;
  endfunction

  task automatic drive(input logic [15:0] v);
    logic [15:0] rise, fall;
    @(negedge clk);
    rise = v & ~chan;
    fall = ~v & chan;
    m_pend = m_pend | (m_en & ((m_pol & rise) | (~m_pol & fall)));
    chan = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [15:0] d;
    rd(2, d);
    check({tag, " pending"}, d, m_pend);
    check({tag, " irq"}, irq, exp_irq());
    check({tag, " wake"}, wake, |(m_pend & m_en));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) m_route[i] = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 / R9: reset values and unused addresses
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      check($sformatf("R1 R9 reset addr %0d", a), d, 16'h0);
    end
    check("R1 irq after reset", irq, 4'h0);
    check("R1 wake after reset", wake, 1'b0);

    // R9: register readback
    wr(0, 16'hA5C3); rd(0, d); check("R9 enable readback", d, 16'hA5C3);
    wr(1, 16'h3C5A); rd(1, d); check("R9 polarity readback", d, 16'h3C5A);
    wr(3, 16'h1B2D); rd(3, d); check("R9 route0 readback", d, 16'h1B2D);
    wr(4, 16'hE4F0); rd(4, d); check("R9 route1 readback", d, 16'hE4F0);
    wr(6, 16'hFFFF); rd(6, d); check("R9 unused addr reads zero", d, 16'h0);
    wr(0, 16'h0); wr(1, 16'h0); wr(3, 16'h0); wr(4, 16'h0);

    // R2: rising selection on line 3, timing of the pending flag
    m_en = 16'h0008; m_pol = 16'h0008;
    wr(0, m_en); wr(1, m_pol);
    @(negedge clk);
    chan[3] = 1'b1;
    repeat (2) @(negedge clk);
    rd(2, d); check("R2 not yet pending after two edges", d, 16'h0);
    @(negedge clk);
    rd(2, d); check("R2 pending on third edge", d, 16'h0008);
    m_pend = 16'h0008;
    drive(16'h0000);
    check_all("R2 falling ignored when rising selected");
    wr(2, 16'hFFFF); m_pend = '0;
    m_pol = 16'h0000; wr(1, m_pol);
    drive(16'h0008);
    check_all("R2 rising ignored when falling selected");
    drive(16'h0000);
    check_all("R2 falling sets pending");

    // R4: write zero keeps, write one clears
    wr(2, 16'h0000);
    check_all("R4 write zero leaves pending");
    wr(2, 16'h0008); m_pend = '0;
    check_all("R4 write one clears");

    // R3: disabled line ignored
    m_en = 16'h0000; wr(0, m_en);
    drive(16'h0020);
    drive(16'h0000);
    check_all("R3 disabled line edges ignored");

    // R7: polarity flips with steady high inputs
    drive(16'hFFFF);
    m_en = 16'hFFFF; wr(0, m_en);
    m_pol = 16'hFFFF; wr(1, m_pol);
    repeat (4) @(negedge clk);
    m_pol = 16'h0000; wr(1, m_pol);
    repeat (4) @(negedge clk);
    m_pol = 16'hFFFF; wr(1, m_pol);
    repeat (4) @(negedge clk);
    check_all("R7 polarity change creates no event");

    // R8: disable a pending line
    m_pol = 16'h0000; wr(1, m_pol);
    drive(16'hFFF7);
    check_all("R8 pending before disable");
    m_en = 16'hFFF7; wr(0, m_en);
    check_all("R8 disabled pending masked but kept");
    wr(2, 16'hFFFF); m_pend = '0;
    drive(16'h0000);
    wr(2, 16'hFFFF); m_pend = '0;

    // R5 / R6: random configurations and stimulus
    for (int it = 0; it < 25; it++) begin
      m_en  = 16'($urandom);
      m_pol = 16'($urandom);
      for (int i = 0; i < 16; i++) m_route[i] = 2'($urandom);
      wr(0, m_en); wr(1, m_pol); wr(3, route_word(0)); wr(4, route_word(1));
      for (int s = 0; s < 6; s++) begin
        drive(16'($urandom));
        check_all($sformatf("R5 R6 random it%0d step%0d", it, s));
      end
      d = 16'($urandom);
      wr(2, d); m_pend = m_pend & ~d;
      check_all($sformatf("R4 random partial clear it%0d", it));
      wr(2, 16'hFFFF); m_pend = '0;
    end

    summary();
    $finish;
  end
endmodule